// File: doc/BRIEF.md
# Instruction byte prefetch buffer

This block sits between instruction memory and the opcode/operand registers of a microcoded processor. Memory delivers 16-bit words. The block keeps up to two of them: an arrival level (F) that takes the memory return, and a delivery level (G) whose bytes go out one at a time. A per-level valid bit tracks what each level holds. Two counters run alongside the levels. The word fetch counter supplies the memory address. The byte consume counter names the byte on `byte_out`, and its low bit picks which half of the G word is delivered.

A flush covers a new program counter, a restart or a taken jump. It drops every buffered byte and reloads both counters from `pc_in`. A reference may still be in flight when a flush arrives. The fetch controller then marks that reference killed, so its data is thrown away when it returns. The controller is a three-state machine:

- **FS_IDLE**: no reference is outstanding.
- **FS_WAIT**: a reference is outstanding and its data is wanted.
- **FS_KILL**: a reference is outstanding and its data will be dropped.

The transitions are:

- **issue** (FS_IDLE to FS_WAIT): `mem_req` and `mem_ack` are both high.
- **return** (FS_WAIT to FS_IDLE): `mem_dvalid` is high and no flush is present. The word is written into F.
- **cancel** (FS_WAIT to FS_KILL): a flush arrives without data in the same cycle.
- **drop** (FS_WAIT to FS_IDLE): a flush and the data arrive in the same cycle. The data is discarded.
- **discard** (FS_KILL to FS_IDLE): `mem_dvalid` is high. The data is discarded.

Reset is synchronous.

Top module: `ifb_prefetch`

## Requirements
- R1: While reset is held, the block clears both valid bits and both counters. In the first cycle after reset, `byte_valid` is 0 and `byte_pc` is 0. `mem_req` is 1 with `mem_addr` 0, provided `stall` is low.
- R2: When `byte_valid` is 1, `byte_out` is a byte of the memory word at word address `byte_pc >> 1`. It is bits [7:0] of that word when `byte_pc[0]` is 0, and bits [15:8] when `byte_pc[0]` is 1. While `byte_take` and `flush` stay low, `byte_out`, `byte_pc` and `byte_valid` do not change.
- R3: A cycle with `byte_valid`, `byte_take` high and `flush` low advances `byte_pc` by one. The G word is released only when the byte taken has `byte_pc[0]` = 1. A `byte_take` while `byte_valid` is 0 has no effect on `byte_pc`.
- R4: `mem_req` is raised only in FS_IDLE, and only when F is empty or a flush is present. `mem_addr` equals the word fetch counter.
- R5: Each accepted request (`mem_req` and `mem_ack`) advances the word fetch counter by one. Successive requests without a flush therefore carry consecutive word addresses.
- R6: A flush loads `byte_pc` with `pc_in` and the fetch counter with `pc_in >> 1`, and clears both valid bits. `byte_valid` is 0 in the next cycle. A `byte_take` in the flush cycle is ignored.
- R7: Data returned for a reference that was outstanding when a flush occurred never reaches `byte_out` (states FS_KILL and drop).
- R8: While `stall` (pause or test mode) is high, `mem_req` is 0.
- R9: A flush in FS_IDLE with `stall` low raises `mem_req` in the same cycle with `mem_addr` = `pc_in >> 1`, even if F is full.
- R10: At most one reference is outstanding: no `mem_req` is raised from the cycle of an accepted request through the cycle its data returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard buffered bytes and reload the counters |
| pc_in | input | PC_W | Byte address loaded on flush |
| stall | input | 1 | Suppress new fetch requests (pause or test) |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | PC_W-1 | Word address of the request |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_dvalid | input | 1 | Returned word is present |
| mem_data | input | 2*BYTE_W | Returned word |
| byte_out | output | BYTE_W | Byte offered to J/H |
| byte_valid | output | 1 | `byte_out` holds a valid byte |
| byte_take | input | 1 | Consumer takes the offered byte |
| byte_pc | output | PC_W | Byte address of `byte_out` |

## Verification
The assertions take three things for granted about the memory side. `mem_dvalid` is raised only for a reference that was accepted earlier. Exactly one return follows each accepted reference. Return data is presented no earlier than the cycle after the accept.

The bench memory model keeps to this. It holds one pending reference, counts down a chosen latency, and answers once. Its return is the word computed from the accepted address, or the inverted word if a flush hit while that reference was pending. A leaked killed response therefore shows up as a wrong byte.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_KILL = 2'd2
    } fetch_st_e;
endpackage

// File: rtl/ifb_fetch_ctl.sv
module ifb_fetch_ctl
    import ifb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic stall,
    input  logic f_full,
    input  logic mem_ack,
    input  logic mem_dvalid,
    output logic mem_req,
    output logic issue,
    output logic fill
);
    fetch_st_e st_q, st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FS_IDLE;
        else     st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FS_IDLE: if (issue) st_nx = FS_WAIT;
            FS_WAIT: begin
                if (mem_dvalid)  st_nx = FS_IDLE;
                else if (flush)  st_nx = FS_KILL;
            end
            FS_KILL: if (mem_dvalid) st_nx = FS_IDLE;
            default: st_nx = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        fill    = 1'b0;
        unique case (st_q)
            FS_IDLE: mem_req = !stall && (flush || !f_full);
            FS_WAIT: fill    = mem_dvalid && !flush;
            FS_KILL: fill    = 1'b0;
            default: mem_req = 1'b0;
        endcase
        issue = mem_req && mem_ack;
    end
endmodule

// File: rtl/ifb_levels.sv
module ifb_levels #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              fill,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              take,
    input  logic              sel_hi,
    output logic              f_full,
    output logic              g_valid,
    output logic [BYTE_W-1:0] byte_out
);
    logic [WORD_W-1:0] f_q, g_q;
    logic              fv_q, gv_q;
    logic              release_g, g_free;

    assign release_g = take && sel_hi;
    assign g_free    = !gv_q || release_g;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            fv_q <= 1'b0;
            gv_q <= 1'b0;
        end else begin
            if (g_free) gv_q <= fv_q;
            if (fill)        fv_q <= 1'b1;
            else if (g_free) fv_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill) f_q <= fill_data;
        if (g_free && fv_q) g_q <= f_q;
    end

    assign f_full   = fv_q;
    assign g_valid  = gv_q;
    assign byte_out = sel_hi ? g_q[WORD_W-1:BYTE_W] : g_q[BYTE_W-1:0];
endmodule

// File: rtl/ifb_counters.sv
module ifb_counters #(
    parameter int PC_W = 16,
    localparam int WA_W = PC_W - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [PC_W-1:0] pc_in,
    input  logic            issue,
    input  logic            take,
    output logic [WA_W-1:0] word_pc,
    output logic [PC_W-1:0] cons_pc
);
    logic [WA_W-1:0] wpc_q;
    logic [PC_W-1:0] bpc_q;
    logic [WA_W-1:0] wbase;

    assign wbase = flush ? pc_in[PC_W-1:1] : wpc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wpc_q <= '0;
            bpc_q <= '0;
        end else begin
            wpc_q <= wbase + WA_W'(issue);
            if (flush)     bpc_q <= pc_in;
            else if (take) bpc_q <= bpc_q + 1'b1;
        end
    end

    assign word_pc = wbase;
    assign cons_pc = bpc_q;
endmodule

// File: rtl/ifb_prefetch.sv
module ifb_prefetch #(
    parameter int PC_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [PC_W-1:0]       pc_in,
    input  logic                  stall,
    output logic                  mem_req,
    output logic [PC_W-2:0]       mem_addr,
    input  logic                  mem_ack,
    input  logic                  mem_dvalid,
    input  logic [2*BYTE_W-1:0]   mem_data,
    output logic [BYTE_W-1:0]     byte_out,
    output logic                  byte_valid,
    input  logic                  byte_take,
    output logic [PC_W-1:0]       byte_pc
);
    logic f_full, issue, fill, take_eff;

    assign take_eff = byte_take && byte_valid && !flush;

    ifb_fetch_ctl u_ctl (
        .clk(clk), .rst(rst), .flush(flush), .stall(stall),
        .f_full(f_full), .mem_ack(mem_ack), .mem_dvalid(mem_dvalid),
        .mem_req(mem_req), .issue(issue), .fill(fill)
    );

    ifb_levels #(.BYTE_W(BYTE_W)) u_lvl (
        .clk(clk), .rst(rst), .flush(flush), .fill(fill),
        .fill_data(mem_data), .take(take_eff), .sel_hi(byte_pc[0]),
        .f_full(f_full), .g_valid(byte_valid), .byte_out(byte_out)
    );

    ifb_counters #(.PC_W(PC_W)) u_cnt (
        .clk(clk), .rst(rst), .flush(flush), .pc_in(pc_in),
        .issue(issue), .take(take_eff),
        .word_pc(mem_addr), .cons_pc(byte_pc)
    );
endmodule

// File: rtl/ifb_prefetch_chk.sv
module ifb_prefetch_chk #(
    parameter int PC_W   = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic [PC_W-1:0]   pc_in,
    input logic              stall,
    input logic              mem_req,
    input logic [PC_W-2:0]   mem_addr,
    input logic              mem_ack,
    input logic              mem_dvalid,
    input logic [BYTE_W-1:0] byte_out,
    input logic              byte_valid,
    input logic              byte_take,
    input logic [PC_W-1:0]   byte_pc
);
    logic out_q;
    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)                   out_q <= 1'b0;
        else if (mem_req && mem_ack) out_q <= 1'b1;
        else if (mem_dvalid)       out_q <= 1'b0;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            a_r1_reset_state: assert (!byte_valid && byte_pc == '0);
    end

    a_r8_stall_blocks_req: assert property (@(posedge clk) disable iff (rst)
        stall |-> !mem_req);

    a_r10_single_ref: assert property (@(posedge clk) disable iff (rst)
        out_q |-> !mem_req);

    a_r6_flush_drops_valid: assert property (@(posedge clk) disable iff (rst)
        flush |=> !byte_valid);

    a_r6_flush_loads_pc: assert property (@(posedge clk) disable iff (rst)
        flush |=> byte_pc == $past(pc_in));

    a_r3_take_steps_pc: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_take && !flush) |=> byte_pc == $past(byte_pc) + 1'b1);

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_take && !flush) |=>
            (byte_valid && $stable(byte_out) && $stable(byte_pc)));

    a_r9_forced_req: assert property (@(posedge clk) disable iff (rst)
        (flush && !stall && !out_q) |-> (mem_req && mem_addr == pc_in[PC_W-1:1]));
endmodule

bind ifb_prefetch ifb_prefetch_chk #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .pc_in(pc_in), .stall(stall),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_dvalid(mem_dvalid), .byte_out(byte_out), .byte_valid(byte_valid),
    .byte_take(byte_take), .byte_pc(byte_pc)
);

// File: tb/sim_ifb_prefetch.sv
module sim_ifb_prefetch;
    localparam int PERIOD = 10;
    localparam int PC_W   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [15:0] pc_in = '0;
    logic        stall = 1'b0;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_dvalid = 1'b0;
    logic [15:0] mem_data = '0;
    logic [7:0]  byte_out;
    logic        byte_valid;
    logic        byte_take = 1'b0;
    logic [15:0] byte_pc;

    always #(PERIOD/2) clk = ~clk;

    ifb_prefetch #(.PC_W(PC_W), .BYTE_W(8)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .pc_in(pc_in), .stall(stall),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_dvalid(mem_dvalid), .mem_data(mem_data), .byte_out(byte_out),
        .byte_valid(byte_valid), .byte_take(byte_take), .byte_pc(byte_pc)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench memory model state
    bit          busy = 0, dv_on = 0, stale = 0;
    int          cnt = 0;
    int          lat = 0;
    logic [14:0] aw = '0;
    logic [14:0] exp_fetch = '0;
    logic [15:0] exp_pc = '0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] bval(input logic [15:0] b);
        logic [15:0] t;
        t = b * 16'd37 + (b >> 4) + 16'd5;
        return t[7:0];
    endfunction

    function automatic logic [15:0] wval(input logic [14:0] w);
        return {bval({w, 1'b1}), bval({w, 1'b0})};
    endfunction

    function automatic logic [15:0] lnext(input logic [15:0] l);
        return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit do_flush, input logic [15:0] target,
                        input bit do_stall, input bit do_take);
        mem_ack = 1'b0;
        if (dv_on) begin
            busy = 0; dv_on = 0; mem_dvalid = 1'b0;
        end
        if (byte_valid) begin
            chk(byte_pc == exp_pc, "R3/R6 byte_pc", byte_pc, exp_pc);
            chk(byte_out == bval(exp_pc), "R2/R7 byte_out", byte_out, bval(exp_pc));
        end
        flush = do_flush; pc_in = target; stall = do_stall; byte_take = do_take;
        if (do_flush && busy) stale = 1;
        if (busy && cnt == 0) begin
            mem_dvalid = 1'b1; dv_on = 1;
            mem_data = stale ? ~wval(aw) : wval(aw);
        end else if (busy) cnt--;
        #1;
        if (busy)     chk(!mem_req, "R10 req while outstanding", mem_req, 0);
        if (do_stall) chk(!mem_req, "R8 req under stall", mem_req, 0);
        if (do_flush && !do_stall && !busy)
            chk(mem_req, "R9 forced req on flush", mem_req, 1);
        if (mem_req) begin
            if (do_flush) chk(mem_addr == target[15:1], "R6/R9 flush addr", mem_addr, target[15:1]);
            else          chk(mem_addr == exp_fetch, "R4/R5 fetch addr", mem_addr, exp_fetch);
        end
        lfsr = lnext(lfsr);
        mem_ack = mem_req && (lfsr[3:2] != 2'b00);
        if (mem_req && mem_ack) begin
            busy = 1; cnt = lat; stale = 0; aw = mem_addr; exp_fetch = mem_addr + 1'b1;
        end else if (do_flush) exp_fetch = target[15:1];
        if (do_flush) exp_pc = target;
        else if (byte_valid && do_take) exp_pc = exp_pc + 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!byte_valid, "R1 byte_valid after reset", byte_valid, 0);
        chk(byte_pc == 0, "R1 byte_pc after reset", byte_pc, 0);
        chk(mem_req && mem_addr == 0, "R1 first request", {mem_req, mem_addr}, {1'b1, 15'd0});
        @(negedge clk);
        // plain streaming from address 0
        lat = 1;
        for (int i = 0; i < 40; i++) step(0, '0, 0, 1'b1);
        // stall holds off requests (R8), take ignored when invalid (R3)
        for (int i = 0; i < 12; i++) step(0, '0, 1, 1'b1);
        for (int i = 0; i < 12; i++) step(0, '0, 0, 1'b0);
        // sweep flush targets and latencies, second flush mid-stream (R7)
        for (int t = 0; t < 32; t++) begin
            for (int l = 0; l < 4; l++) begin
                lat = l;
                step(1, 16'(t * 3 + 100), 0, 1'b1);
                for (int k = 0; k < 30; k++) begin
                    lfsr = lnext(lfsr);
                    if (k == 2 + l || k == 9)
                        step(1, 16'(t ^ 5) + 16'(k), lfsr[0] & lfsr[5], lfsr[1]);
                    else
                        step(0, '0, lfsr[4] & lfsr[6] & lfsr[7], lfsr[1] | lfsr[2]);
                end
            end
        end
        // back-to-back flushes while a reference is pending (R7)
        lat = 3;
        for (int i = 0; i < 6; i++) step(1, 16'(200 + i), 0, 1'b1);
        for (int i = 0; i < 40; i++) step(0, '0, 0, 1'b1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule